// File: doc/BRIEF.md
# Three-Channel Interval Timer with Status Read-Back

This block holds three independent 16-bit down-counters behind a byte-wide register bus with a 2-bit address. Software programs each channel through a control port. It then loads a count through that channel's data port and observes the channel's OUT line. The block runs on one system clock. Each channel advances only on cycles where its own count-tick input is high, so each channel can run from a different count rate.

Two counting behaviours are built in. The first is a periodic divide-by-N generator that drops OUT for one tick per period. The second is a one-shot strobe that fires once after a count write and stays quiet until software writes a new count. Software can freeze a channel's count for a clean multi-byte read. A read-back command can also capture a status byte and the count of any subset of channels in one bus write. The status byte carries the OUT level, a pending-load flag and the programmed control bits.

Top module: `itm_readback_timer`

## Requirements
- R1: Bus address 0, 1 and 2 reach the data ports of channel 0, 1 and 2, and address 3 is the control port. A read at address 3 returns 0x00.
- R2: A control write with bits 7:6 not equal to 11 and bits 5:4 not equal to 00 programs one channel. Bits 7:6 select the channel (00, 01 or 10). Bits 5:4 select the byte format (01 low only, 10 high only, 11 low then high). Bits 3:1 give the mode and bit 0 is the BCD flag, which is only stored. The write forces that channel's OUT high, sets its pending-load flag, restarts byte sequencing and stops counting.
- R3: In format 01 a single write sets the count with the high byte zero. In format 10 a single write sets the count with the low byte zero. In format 11 the low byte must be followed by the high byte, and nothing is loaded until the high byte arrives. A completed count moves into the counter on the channel's next tick, and the pending-load flag clears on that tick.
- R4: In the periodic mode (mode 010 or 110) with count N, OUT is low for exactly one tick in each period of N ticks. That tick is the N-th tick after the load tick, counted from the load tick as tick 1. The counter then reloads N on the following tick.
- R5: In the periodic mode, a count written while the channel is already running takes effect only at the next reload, and the period in progress completes with the old count.
- R6: In the strobe mode (mode 100) with count N, OUT is low for exactly one tick: the (N+1)-th tick after the count write. After that OUT stays high until another count is written.
- R7: A count of 0 behaves as 65536.
- R8: A latch command (bits 5:4 = 00, bits 7:6 = channel) freezes that channel's count for reading in its byte format. Further latch commands are ignored until the frozen value has been fully read.
- R9: A read-back command (bits 7:6 = 11) applies to each channel whose select bit is set: bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2. A clear bit 5 latches the count and a clear bit 4 latches the status. The status byte is {OUT, pending-load flag, control bits 5:0}.
- R10: When both status and count are latched, the first read returns the status byte. The next reads return the latched count in the channel's byte order.
- R11: With nothing latched, a read returns the live count in the byte format. In format 11, successive reads alternate low byte then high byte.
- R12: After reset every channel holds control bits 000000 with OUT high and the pending-load flag clear. In modes other than the periodic and strobe modes, a channel does not count or load, and OUT stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 to 2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; advances read sequencing at the clock edge |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| cnt_tick | input | 3 | Per-channel count enable, one bit per channel |
| tmr_out | output | 3 | Per-channel OUT line |

## Verification
The periodic mode is run with a four-count that is rewritten mid-period and with a high-byte-only count of 256. These runs separate correct deferral of a new count from an immediate reload, and check that the format places the byte correctly. The strobe mode is tried with counts 5, 2 and 0. These runs tell an N+1 pulse from an off-by-one pulse, check that the one-shot does not repeat, and check the 65536 wrap. Random tick masks with random counts on two channels at once show whether channels interfere, or whether a pulse depends on ticks that arrive as gaps rather than on consecutive cycles. Latch, read-back and live reads are interleaved on one channel. This shows whether the status has priority, whether the latched value is held across repeated latch commands, and whether the byte toggle stays aligned.

// File: rtl/itm_pkg.sv
// Package itm_pkg
// Shared constants, the per-channel control record and mode helpers for the
// three-channel interval timer. Assumes a 16-bit counter read as two bytes.
package itm_pkg;

    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 2 * BYTE_W;
    localparam int NUM_CH    = 3;
    localparam int ADDR_W    = 2;
    localparam int CFG_W     = 6;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'b11;

    typedef enum logic [1:0] {
        FMT_LATCH = 2'b00,
        FMT_LO    = 2'b01,
        FMT_HI    = 2'b10,
        FMT_LOHI  = 2'b11
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [2:0] mode;
        logic       bcd;
    } chan_cfg_t;

    // Periodic divide-by-N mode (mode codes 010 and 110).
    function automatic logic is_rate(input logic [2:0] m);
        return m[1:0] == 2'b10;
    endfunction

    // Software-triggered one-shot strobe mode (mode code 100).
    function automatic logic is_strobe(input logic [2:0] m);
        return m == 3'b100;
    endfunction

endpackage

// File: rtl/itm_cmd_decode.sv
// Module itm_cmd_decode
// Turns one bus cycle into per-channel strobes: configuration, count latch,
// status latch, data write and data read. Purely combinational; assumes at
// most one of bus_wr / bus_rd is acted upon per channel per cycle.
module itm_cmd_decode
    import itm_pkg::*;
(
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [NUM_CH-1:0]   cfg_wr,
    output logic [NUM_CH-1:0]   cnt_req,
    output logic [NUM_CH-1:0]   st_req,
    output logic [NUM_CH-1:0]   data_wr,
    output logic [NUM_CH-1:0]   data_rd,
    output chan_cfg_t           cfg_val
);

    logic ctrl_wr;
    logic is_rb;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
    assign is_rb   = (bus_wdata[7:6] == 2'b11);
    assign cfg_val = chan_cfg_t'(bus_wdata[CFG_W-1:0]);

    // Purpose: route data-port cycles and decode control-port commands.
    always_comb begin
        cfg_wr  = '0;
        cnt_req = '0;
        st_req  = '0;
        data_wr = '0;
        data_rd = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            data_wr[i] = bus_wr && (bus_addr == ADDR_W'(i));
            data_rd[i] = bus_rd && (bus_addr == ADDR_W'(i));
            if (ctrl_wr) begin
                if (is_rb) begin
                    if (bus_wdata[1+i]) begin
                        cnt_req[i] = !bus_wdata[5];
                        st_req[i]  = !bus_wdata[4];
                    end
                end else if (bus_wdata[7:6] == 2'(i)) begin
                    if (bus_wdata[5:4] == FMT_LATCH) cnt_req[i] = 1'b1;
                    else                             cfg_wr[i]  = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/itm_count_core.sv
// Module itm_count_core
// One channel's counting element: control record, count holding register,
// reload register, down-counter and OUT. Counts only on cycles with tick high.
// Assumes the control write has priority over a tick in the same cycle.
module itm_count_core
    import itm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                cfg_wr,
    input  chan_cfg_t           cfg_in,
    input  logic                data_wr,
    input  logic [BYTE_W-1:0]   wdata,
    output chan_cfg_t           cfg_q,
    output logic [CNT_W-1:0]    count_q,
    output logic                out_q,
    output logic                null_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] reld_q;
    logic             pend_q;
    logic             wtog_q;
    logic             armed_q;
    logic             run_q;
    logic             rate;
    logic             strobe;

    assign rate   = is_rate(cfg_q.mode);
    assign strobe = is_strobe(cfg_q.mode);

    // Purpose: programming, count writes and per-tick counting for one channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            count_q <= '0;
            init_q  <= '0;
            reld_q  <= '0;
            pend_q  <= 1'b0;
            wtog_q  <= 1'b0;
            armed_q <= 1'b0;
            run_q   <= 1'b0;
            out_q   <= 1'b1;
            null_q  <= 1'b0;
        end else if (cfg_wr) begin
            cfg_q   <= cfg_in;
            out_q   <= 1'b1;
            null_q  <= 1'b1;
            pend_q  <= 1'b0;
            wtog_q  <= 1'b0;
            armed_q <= 1'b0;
            run_q   <= 1'b0;
        end else begin
            if (tick) begin
                if (strobe) begin
                    if (pend_q) begin
                        count_q <= init_q;
                        pend_q  <= 1'b0;
                        null_q  <= 1'b0;
                        armed_q <= 1'b1;
                        out_q   <= 1'b1;
                    end else begin
                        count_q <= count_q - ONE;
                        if (armed_q && count_q == ONE) begin
                            out_q   <= 1'b0;
                            armed_q <= 1'b0;
                        end else begin
                            out_q   <= 1'b1;
                        end
                    end
                end else if (rate) begin
                    if (!run_q) begin
                        if (pend_q) begin
                            count_q <= init_q;
                            reld_q  <= init_q;
                            pend_q  <= 1'b0;
                            null_q  <= 1'b0;
                            run_q   <= 1'b1;
                            out_q   <= 1'b1;
                        end
                    end else if (count_q == ONE) begin
                        out_q <= 1'b1;
                        if (pend_q) begin
                            count_q <= init_q;
                            reld_q  <= init_q;
                            pend_q  <= 1'b0;
                            null_q  <= 1'b0;
                        end else begin
                            count_q <= reld_q;
                        end
                    end else begin
                        count_q <= count_q - ONE;
                        out_q   <= (count_q != TWO);
                    end
                end
            end
            if (data_wr) begin
                case (cfg_q.fmt)
                    FMT_LO: begin
                        init_q <= {{(CNT_W-BYTE_W){1'b0}}, wdata};
                        pend_q <= 1'b1;
                        null_q <= 1'b1;
                    end
                    FMT_HI: begin
                        init_q <= {wdata, {BYTE_W{1'b0}}};
                        pend_q <= 1'b1;
                        null_q <= 1'b1;
                    end
                    FMT_LOHI: begin
                        if (!wtog_q) begin
                            init_q[BYTE_W-1:0] <= wdata;
                            wtog_q <= 1'b1;
                        end else begin
                            init_q[CNT_W-1:BYTE_W] <= wdata;
                            wtog_q <= 1'b0;
                            pend_q <= 1'b1;
                            null_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // A low OUT never lasts past the next tick (R4 and R6).
    assert_out_low_one_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_q && tick) |=> out_q);

    // OUT moves only on a tick or a control write (R12).
    assert_out_steady_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cfg_wr) |=> $stable(out_q));

    // A control write leaves OUT high and a load pending.
    assert_cfg_forces_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (out_q && null_q));

    // The pending-load flag can only clear on a tick.
    assert_null_clears_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (null_q && !tick) |=> null_q);

endmodule

// File: rtl/itm_latch_port.sv
// Module itm_latch_port
// One channel's read side: status latch, count latch, read byte toggle and the
// read data selection. Assumes status and count snapshots come from the core.
module itm_latch_port
    import itm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  fmt_e                fmt,
    input  logic [CNT_W-1:0]    count,
    input  logic [BYTE_W-1:0]   status,
    input  logic                cfg_wr,
    input  logic                cnt_req,
    input  logic                st_req,
    input  logic                data_rd,
    output logic [BYTE_W-1:0]   rdata
);

    logic                st_v;
    logic [BYTE_W-1:0]   st_byte;
    logic                cl_v;
    logic [CNT_W-1:0]    cl_val;
    logic                rtog;
    logic [CNT_W-1:0]    src;

    // Purpose: capture latches on request and retire them as they are read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_v    <= 1'b0;
            st_byte <= '0;
            cl_v    <= 1'b0;
            cl_val  <= '0;
            rtog    <= 1'b0;
        end else if (cfg_wr) begin
            st_v <= 1'b0;
            cl_v <= 1'b0;
            rtog <= 1'b0;
        end else begin
            if (data_rd) begin
                if (st_v) begin
                    st_v <= 1'b0;
                end else if (fmt == FMT_LOHI) begin
                    rtog <= !rtog;
                    if (cl_v && rtog) cl_v <= 1'b0;
                end else begin
                    cl_v <= 1'b0;
                end
            end
            if (cnt_req && !cl_v) begin
                cl_v   <= 1'b1;
                cl_val <= count;
            end
            if (st_req && !st_v) begin
                st_v    <= 1'b1;
                st_byte <= status;
            end
        end
    end

    assign src = cl_v ? cl_val : count;

    // Purpose: pick status, latched or live byte for the current read.
    always_comb begin
        if (st_v) begin
            rdata = st_byte;
        end else begin
            case (fmt)
                FMT_HI:   rdata = src[CNT_W-1:BYTE_W];
                FMT_LOHI: rdata = rtog ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
                default:  rdata = src[BYTE_W-1:0];
            endcase
        end
    end

    // A held count survives ticks and repeated latch commands until read.
    assert_latch_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_v && !data_rd && !cfg_wr) |=> (cl_v && $stable(cl_val)));

    // A captured status stays until it is read.
    assert_status_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_v && !data_rd && !cfg_wr) |=> (st_v && $stable(st_byte)));

endmodule

// File: rtl/itm_readback_timer.sv
// Module itm_readback_timer
// Top of the three-channel interval timer: command decode, one counting core
// and one latch port per channel, and the bus read multiplexer.
// Assumes cnt_tick is synchronous to clk, one bit per channel.
module itm_readback_timer
    import itm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [7:0]          bus_wdata,
    input  logic                bus_rd,
    output logic [7:0]          bus_rdata,
    input  logic [2:0]          cnt_tick,
    output logic [2:0]          tmr_out
);

    logic [NUM_CH-1:0]              cfg_wr;
    logic [NUM_CH-1:0]              cnt_req;
    logic [NUM_CH-1:0]              st_req;
    logic [NUM_CH-1:0]              data_wr;
    logic [NUM_CH-1:0]              data_rd;
    chan_cfg_t                      cfg_val;
    logic [NUM_CH-1:0][BYTE_W-1:0]  ch_rdata;

    itm_cmd_decode u_decode (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cfg_wr    (cfg_wr),
        .cnt_req   (cnt_req),
        .st_req    (st_req),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .cfg_val   (cfg_val)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        chan_cfg_t          cfg_q;
        logic [CNT_W-1:0]   count_q;
        logic               out_q;
        logic               null_q;

        itm_count_core u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (cnt_tick[g]),
            .cfg_wr  (cfg_wr[g]),
            .cfg_in  (cfg_val),
            .data_wr (data_wr[g]),
            .wdata   (bus_wdata),
            .cfg_q   (cfg_q),
            .count_q (count_q),
            .out_q   (out_q),
            .null_q  (null_q)
        );

        itm_latch_port u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .fmt     (cfg_q.fmt),
            .count   (count_q),
            .status  ({out_q, null_q, cfg_q}),
            .cfg_wr  (cfg_wr[g]),
            .cnt_req (cnt_req[g]),
            .st_req  (st_req[g]),
            .data_rd (data_rd[g]),
            .rdata   (ch_rdata[g])
        );

        assign tmr_out[g] = out_q;
    end

    // Purpose: return the addressed channel's byte; the control port reads 0.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(i)) bus_rdata = ch_rdata[i];
        end
    end

endmodule

// File: tb/test_itm_readback_timer.sv
// Bench for itm_readback_timer: directed corner cases plus seeded random
// tick patterns, with expected OUT levels from bench functions.
module test_itm_readback_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [2:0] cnt_tick = '0;
    logic [2:0] tmr_out;

    int checks = 0;
    int errors = 0;

    itm_readback_timer i_itm_readback_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .cnt_tick  (cnt_tick),
        .tmr_out   (tmr_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All bus tasks start just after a falling edge and end at the next one.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tk(input logic [2:0] m);
        cnt_tick = m;
        @(negedge clk);
        cnt_tick = '0;
    endtask

    function automatic int eff(input int n);
        return (n == 0) ? 65536 : n;
    endfunction

    // Periodic mode: low on every N-th tick, tick 1 being the load tick.
    function automatic logic exp_rate(input int n, input int k);
        return !(k > 0 && (k % eff(n)) == 0);
    endfunction

    // Strobe mode: single low on tick N+1 after the write.
    function automatic logic exp_strobe(input int n, input int k);
        return !(k == eff(n) + 1);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n1, n2, k1, k2;
        logic [2:0] m;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        chk("R12 reset OUT", tmr_out, 3'b111);
        wr(2'd3, 8'hEE);
        for (int i = 0; i < 3; i++) begin
            rd(2'(i), d);
            chk("R12 R9 reset status", d, 8'h80);
        end
        // R1: control port reads zero
        rd(2'd3, d);
        chk("R1 control port read", d, 8'h00);

        // R2 R9: program channel 0, strobe mode, low-then-high
        wr(2'd3, 8'h38);
        wr(2'd3, 8'hE2);
        rd(2'd0, d);
        chk("R9 status after control write", d, 8'hF8);

        // R3: low byte alone does not load
        wr(2'd0, 8'h05);
        tk(3'b001); tk(3'b001);
        wr(2'd3, 8'hE2);
        rd(2'd0, d);
        chk("R3 pending kept after low byte", d, 8'hF8);
        chk("R3 OUT high before load", tmr_out[0], 1'b1);
        wr(2'd0, 8'h00);
        tk(3'b001);
        chk("R6 strobe tick 1", tmr_out[0], exp_strobe(5, 1));
        wr(2'd3, 8'hE2);
        rd(2'd0, d);
        chk("R3 pending cleared on load", d, 8'hB8);

        // R11: live read in low-then-high order
        rd(2'd0, d); chk("R11 live low", d, 8'h05);
        rd(2'd0, d); chk("R11 live high", d, 8'h00);

        // R6: single strobe on tick N+1, no repeat
        for (int k = 2; k <= 12; k++) begin
            tk(3'b001);
            chk("R6 strobe", tmr_out[0], exp_strobe(5, k));
        end

        // R8: latch holds, second latch ignored
        wr(2'd3, 8'h00);
        tk(3'b001); tk(3'b001);
        wr(2'd3, 8'h00);
        tk(3'b001);
        rd(2'd0, d); chk("R8 latched low", d, 8'hFA);
        rd(2'd0, d); chk("R8 latched high", d, 8'hFF);
        rd(2'd0, d); chk("R11 live low after latch", d, 8'hF7);
        rd(2'd0, d); chk("R11 live high after latch", d, 8'hFF);

        // R10: status then count
        wr(2'd3, 8'hC2);
        rd(2'd0, d); chk("R10 status first", d, 8'hB8);
        rd(2'd0, d); chk("R10 count low", d, 8'hF7);
        rd(2'd0, d); chk("R10 count high", d, 8'hFF);

        // R6 re-arm with N=2, then R2 control write forces OUT high
        wr(2'd0, 8'h02);
        wr(2'd0, 8'h00);
        for (int k = 1; k <= 3; k++) begin
            tk(3'b001);
            chk("R6 rearmed strobe", tmr_out[0], exp_strobe(2, k));
        end
        wr(2'd3, 8'h38);
        chk("R2 control write forces OUT high", tmr_out[0], 1'b1);
        wr(2'd3, 8'hE2);
        rd(2'd0, d);
        chk("R2 pending flag set by control write", d, 8'hF8);

        // R4 R5: channel 1 periodic, count 4, rewritten to 6 mid-period
        wr(2'd3, 8'h54);
        wr(2'd1, 8'h04);
        for (int k = 1; k <= 22; k++) begin
            if (k == 3) wr(2'd1, 8'h06);
            tk(3'b010);
            chk("R5 R4 periodic with deferred count", tmr_out[1],
                !(k == 4 || (k >= 10 && ((k - 4) % 6) == 0)));
        end

        // R3 R4: channel 2 periodic, high byte only -> 256
        wr(2'd3, 8'hA4);
        wr(2'd2, 8'h01);
        for (int k = 1; k <= 520; k++) begin
            tk(3'b100);
            chk("R3 R4 high-byte count", tmr_out[2], exp_rate(256, k));
        end

        // R12: unsupported mode idles
        wr(2'd3, 8'h70);
        wr(2'd1, 8'h03);
        wr(2'd1, 8'h00);
        for (int k = 1; k <= 10; k++) begin
            tk(3'b010);
            chk("R12 idle mode OUT", tmr_out[1], 1'b1);
        end

        // R9: one command reads status of two channels
        wr(2'd3, 8'hEC);
        rd(2'd1, d); chk("R9 multi status ch1", d, 8'hF0);
        rd(2'd2, d); chk("R9 multi status ch2", d, 8'hA4);

        // R7: count 0 in strobe mode is 65536
        wr(2'd3, 8'hB8);
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h00);
        for (int k = 1; k <= 65538; k++) begin
            tk(3'b100);
            chk("R7 zero count strobe", tmr_out[2], exp_strobe(0, k));
        end

        // Random ticks: ch1 periodic, ch2 strobe (R4 R6)
        n1 = 2 + int'($urandom % 39);
        n2 = 1 + int'($urandom % 60);
        wr(2'd3, 8'h54);
        wr(2'd1, 8'(n1));
        wr(2'd3, 8'h98);
        wr(2'd2, 8'(n2));
        k1 = 0; k2 = 0;
        for (int s = 0; s < 400; s++) begin
            m = 3'($urandom % 8);
            tk(m);
            if (m[1]) k1++;
            if (m[2]) k2++;
            chk("R4 random periodic", tmr_out[1], exp_rate(n1, k1));
            chk("R6 random strobe", tmr_out[2], exp_strobe(n2, k2));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule